// File: doc/BRIEF.md
# Bit-oriented message loopback controller

This block listens to the serial data-link bit stream of a T1 extended superframe and picks out bit-oriented messages. A message is a 16-bit pattern: a zero, six code bits, a zero, then eight ones. The block extracts the 6-bit code and, if configured to, requires the same code several times in a row before it acts. Each accepted message produces a one-cycle accept pulse with the code beside it, so that a downstream store can keep it tagged as a bit-oriented message.

Accepted codes drive two loopback controls, a payload loop and a line (remote) loop. Each has its own auto-switching enable. A loop that was switched on by a message is ORed with a register-forced bit for the same loop. Activation is refused while the local loop is held on. Four sticky flags record which loop codes were seen, whether or not switching is enabled. Each flag can be masked from a single interrupt line and is cleared by a write-one strobe.

Top module: `bom_loop_ctrl`

## Requirements
- R1: A message is recognised when the last 16 valid data-link bits, in arrival order, are a 0, six code bits, a 0 and eight 1s. The first code bit to arrive becomes bit 5 of `msg_code`.
- R2: With `filter_en` low, every recognised message raises `msg_accept` for exactly one cycle, two clock cycles after the clock edge that samples its last bit, with `msg_code` valid in that cycle.
- R3: With `filter_en` high, a message is accepted only when it is the 7th consecutive recognised message carrying the same code. Further repeats are not accepted again, and a different code restarts the count.
- R4: With `auto_pl_en` high, payload activate (001010) turns the auto payload loop on unless `force_local` is high. Payload deactivate (011001) turns it off.
- R5: With `auto_ln_en` high, line activate (000111) turns the auto remote loop on unless `force_local` is high. Line deactivate (011100) turns it off. The two loops act independently.
- R6: `payload_loop` is the auto payload loop ORed with `force_pl`, and `remote_loop` is the auto remote loop ORed with `force_rl`. A forced loop therefore stays on after a deactivate code.
- R7: Driving an auto enable low drops the loop it switched, from the next cycle on. Raising an enable after a code was accepted does not switch that loop.
- R8: Accepted codes set sticky flags regardless of the enables: payload activate sets status[0], payload deactivate sets status[1], line activate sets status[2], line deactivate sets status[3]. Other codes set none.
- R9: Universal deactivate (010010) sets status[1] and status[3] even when no loop is on, and drops each auto loop whose enable is high.
- R10: A high bit of `status_clr` clears that status bit at the next edge. A flag being set in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit is high and its `irq_mask` bit (1 = masked) is low.
- R12: While `rst_n` is low at a clock edge, both auto loops, all flags, the repeat counter and `msg_accept` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dl_valid | input | 1 | Qualifies `dl_bit` this cycle |
| dl_bit | input | 1 | Serial data-link bit |
| filter_en | input | 1 | Require 7 identical repeats before accepting |
| auto_pl_en | input | 1 | Enable auto switching of the payload loop |
| auto_ln_en | input | 1 | Enable auto switching of the remote loop |
| force_pl | input | 1 | Register-forced payload loop |
| force_rl | input | 1 | Register-forced remote loop |
| force_local | input | 1 | Local loop active; blocks auto activation |
| status_clr | input | 4 | Write-one-to-clear strobe for the status flags |
| irq_mask | input | 4 | Interrupt mask per flag, 1 = masked |
| payload_loop | output | 1 | Effective payload loop control |
| remote_loop | output | 1 | Effective remote loop control |
| status | output | 4 | Sticky flags: payload act, payload deact, line act, line deact |
| irq | output | 1 | OR of the unmasked flags |
| msg_accept | output | 1 | One-cycle pulse for an accepted message |
| msg_code | output | 6 | Code of the accepted message |

## Verification
If the shift register is misaligned or the code bits are reversed, the wrong value shows on `msg_code`, or no `msg_accept` pulse appears, two cycles after the last bit. A repeat counter that is off by one shows up as an accept on the 6th or 8th repeat instead of the 7th. A wrong auto-loop state shows on `payload_loop` or `remote_loop` one cycle after the accept pulse, or one cycle after an enable falls. Flag errors show on `status` and `irq` in that same cycle and persist until cleared, so they remain visible to any later check.

// File: rtl/bom_pkg.sv
// Shared constants for the bit-oriented message loopback controller.
// Assumes 6-bit message codes and a 4-flag status vector.
package bom_pkg;
    localparam int CODE_W    = 6;
    localparam int NUM_FLAGS = 4;

    localparam logic [CODE_W-1:0] C_LN_ACT   = 6'b000111;
    localparam logic [CODE_W-1:0] C_LN_DEACT = 6'b011100;
    localparam logic [CODE_W-1:0] C_PL_ACT   = 6'b001010;
    localparam logic [CODE_W-1:0] C_PL_DEACT = 6'b011001;
    localparam logic [CODE_W-1:0] C_UNIV     = 6'b010010;

    localparam int F_PL_ACT   = 0;
    localparam int F_PL_DEACT = 1;
    localparam int F_LN_ACT   = 2;
    localparam int F_LN_DEACT = 3;
endpackage

// File: rtl/bom_hunter.sv
// Serial pattern hunter: shifts in valid data-link bits and flags a
// message when the window holds 0, code, 0 and a run of ones.
// Assumes the first code bit received is the code MSB.
module bom_hunter #(
    parameter int CODE_W = 6,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              det,
    output logic [CODE_W-1:0] det_code
);
    localparam int FRAME_W = CODE_W + 2 + FLAG_W;

    logic [FRAME_W-1:0] win_q;
    logic [FRAME_W-1:0] win_next;
    logic               hit;

    // Next window contents and pattern match on it.
    always_comb begin
        win_next = {win_q[FRAME_W-2:0], bit_in};
        hit      = !win_next[FRAME_W-1] && !win_next[FLAG_W] &&
                   (&win_next[FLAG_W-1:0]);
    end

    // Window register and registered detect strobe with code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            det      <= 1'b0;
            det_code <= '0;
        end else begin
            det <= 1'b0;
            if (bit_valid) begin
                win_q <= win_next;
                det   <= hit;
                if (hit) begin
                    det_code <= win_next[FRAME_W-2:FLAG_W+1];
                end
            end
        end
    end
endmodule

// File: rtl/bom_repeat_filter.sv
// Repeat filter: counts consecutive identical detected codes and issues
// an accept strobe either on every detect or on the REPEAT-th repeat.
// Assumes detect strobes are single-cycle.
module bom_repeat_filter #(
    parameter int CODE_W = 6,
    parameter int REPEAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filter_en,
    input  logic              det,
    input  logic [CODE_W-1:0] det_code,
    output logic              acc,
    output logic [CODE_W-1:0] acc_code
);
    localparam int             CNT_W = $clog2(REPEAT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(REPEAT);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_n;
    logic [CODE_W-1:0] prev_q;
    logic              same;

    // Next repeat count, saturating at the limit.
    always_comb begin
        same = (cnt_q != '0) && (det_code == prev_q);
        if (!same) begin
            cnt_n = CNT_W'(1);
        end else if (cnt_q == LIM) begin
            cnt_n = LIM;
        end else begin
            cnt_n = cnt_q + 1'b1;
        end
    end

    // Count, previous code and accept strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            prev_q   <= '0;
            acc      <= 1'b0;
            acc_code <= '0;
        end else begin
            acc <= 1'b0;
            if (det) begin
                cnt_q    <= cnt_n;
                prev_q   <= det_code;
                acc_code <= det_code;
                acc      <= filter_en ? ((cnt_n == LIM) && (cnt_q != LIM)) : 1'b1;
            end
        end
    end
endmodule

// File: rtl/bom_auto_loop.sv
// One auto-switched loop: set by an activate hit unless the local loop
// holds, cleared by a deactivate hit or a low enable, ORed with force.
module bom_auto_loop (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic local_hold,
    input  logic act_hit,
    input  logic deact_hit,
    input  logic force_in,
    output logic loop_out
);
    logic auto_q;

    // Auto loop state register.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            auto_q <= 1'b0;
        end else if (deact_hit) begin
            auto_q <= 1'b0;
        end else if (act_hit && !local_hold) begin
            auto_q <= 1'b1;
        end
    end

    // Effective loop control.
    always_comb begin
        loop_out = auto_q | force_in;
    end
endmodule

// File: rtl/bom_loop_ctrl.sv
// Top: message hunter, repeat filter, code decode, two auto loops and
// sticky status flags with maskable interrupt.
// Assumes synchronous active-low reset and one data-link bit per cycle max.
module bom_loop_ctrl
    import bom_pkg::*;
#(
    parameter int FLAG_W = 8,
    parameter int REPEAT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dl_valid,
    input  logic                 dl_bit,
    input  logic                 filter_en,
    input  logic                 auto_pl_en,
    input  logic                 auto_ln_en,
    input  logic                 force_pl,
    input  logic                 force_rl,
    input  logic                 force_local,
    input  logic [NUM_FLAGS-1:0] status_clr,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    output logic                 payload_loop,
    output logic                 remote_loop,
    output logic [NUM_FLAGS-1:0] status,
    output logic                 irq,
    output logic                 msg_accept,
    output logic [CODE_W-1:0]    msg_code
);
    logic                 det;
    logic [CODE_W-1:0]    det_code;
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 univ_hit;

    bom_hunter #(.CODE_W(CODE_W), .FLAG_W(FLAG_W)) i_hunter (
        .clk(clk), .rst_n(rst_n), .bit_valid(dl_valid), .bit_in(dl_bit),
        .det(det), .det_code(det_code)
    );

    bom_repeat_filter #(.CODE_W(CODE_W), .REPEAT(REPEAT)) i_filter (
        .clk(clk), .rst_n(rst_n), .filter_en(filter_en),
        .det(det), .det_code(det_code),
        .acc(msg_accept), .acc_code(msg_code)
    );

    // Decode accepted codes into flag set requests.
    always_comb begin
        univ_hit               = msg_accept && (msg_code == C_UNIV);
        set_vec                = '0;
        set_vec[F_PL_ACT]      = msg_accept && (msg_code == C_PL_ACT);
        set_vec[F_PL_DEACT]    = (msg_accept && (msg_code == C_PL_DEACT)) || univ_hit;
        set_vec[F_LN_ACT]      = msg_accept && (msg_code == C_LN_ACT);
        set_vec[F_LN_DEACT]    = (msg_accept && (msg_code == C_LN_DEACT)) || univ_hit;
    end

    bom_auto_loop i_pl_loop (
        .clk(clk), .rst_n(rst_n), .enable(auto_pl_en), .local_hold(force_local),
        .act_hit(set_vec[F_PL_ACT]), .deact_hit(set_vec[F_PL_DEACT]),
        .force_in(force_pl), .loop_out(payload_loop)
    );

    bom_auto_loop i_rl_loop (
        .clk(clk), .rst_n(rst_n), .enable(auto_ln_en), .local_hold(force_local),
        .act_hit(set_vec[F_LN_ACT]), .deact_hit(set_vec[F_LN_DEACT]),
        .force_in(force_rl), .loop_out(remote_loop)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        // Sticky flag: set wins over write-one clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[g] <= 1'b0;
            end else begin
                status[g] <= set_vec[g] | (status[g] & ~status_clr[g]);
            end
        end
    end

    // Interrupt from unmasked flags.
    always_comb begin
        irq = |(status & ~irq_mask);
    end
endmodule

// File: rtl/bom_loop_ctrl_chk.sv
// Assertion checker for bom_loop_ctrl, bound to every instance.
module bom_loop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_pl_en,
    input logic       auto_ln_en,
    input logic       force_pl,
    input logic       force_rl,
    input logic       force_local,
    input logic [3:0] status_clr,
    input logic       payload_loop,
    input logic       remote_loop,
    input logic [3:0] status,
    input logic       msg_accept
);
    a_r7_pl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_pl_en |=> (payload_loop == force_pl));
    a_r7_rl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_ln_en |=> (remote_loop == force_rl));
    a_r6_pl_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_pl |-> payload_loop);
    a_r6_rl_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_rl |-> remote_loop);
    a_r4_local_block: assert property (@(posedge clk) disable iff (!rst_n)
        (force_local && !payload_loop) |=> (payload_loop == force_pl));
    a_r5_local_block: assert property (@(posedge clk) disable iff (!rst_n)
        (force_local && !remote_loop) |=> (remote_loop == force_rl));
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~status_clr)) |=>
        ((status & $past(status & ~status_clr)) == $past(status & ~status_clr)));
    a_r8_set_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~$past(status))) |-> $past(msg_accept));
    a_r2_accept_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        msg_accept |=> !msg_accept);
endmodule

bind bom_loop_ctrl bom_loop_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .auto_pl_en(auto_pl_en), .auto_ln_en(auto_ln_en),
    .force_pl(force_pl), .force_rl(force_rl), .force_local(force_local),
    .status_clr(status_clr), .payload_loop(payload_loop), .remote_loop(remote_loop),
    .status(status), .msg_accept(msg_accept)
);

// File: tb/test_bom_loop_ctrl.sv
module test_bom_loop_ctrl;
    localparam logic [5:0] LA = 6'b000111, LD = 6'b011100, PA = 6'b001010,
                           PD = 6'b011001, UD = 6'b010010, BRK = 6'b000000;

    logic clk = 0, rst_n = 0, dl_valid = 0, dl_bit = 1, filter_en = 0;
    logic auto_pl_en = 0, auto_ln_en = 0, force_pl = 0, force_rl = 0, force_local = 0;
    logic [3:0] status_clr = 0, irq_mask = 0;
    logic payload_loop, remote_loop, irq, msg_accept;
    logic [3:0] status;
    logic [5:0] msg_code;

    int checks = 0, errors = 0, acc_cnt = 0, cycles = 0;
    logic [5:0] last_code = 0;
    logic m_pl = 0, m_rl = 0;
    logic [3:0] m_st = 0;

    bom_loop_ctrl i_bom_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .dl_valid(dl_valid), .dl_bit(dl_bit),
        .filter_en(filter_en), .auto_pl_en(auto_pl_en), .auto_ln_en(auto_ln_en),
        .force_pl(force_pl), .force_rl(force_rl), .force_local(force_local),
        .status_clr(status_clr), .irq_mask(irq_mask), .payload_loop(payload_loop),
        .remote_loop(remote_loop), .status(status), .irq(irq),
        .msg_accept(msg_accept), .msg_code(msg_code)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (rst_n && msg_accept) begin
        acc_cnt++;
        last_code = msg_code;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flags set by a code (R8, R9).
    function automatic logic [3:0] set_bits(input logic [5:0] c);
        set_bits = 4'b0000;
        if (c == PA) set_bits[0] = 1;
        if (c == PD || c == UD) set_bits[1] = 1;
        if (c == LA) set_bits[2] = 1;
        if (c == LD || c == UD) set_bits[3] = 1;
    endfunction

    // Next auto loop state (R4, R5, R9).
    function automatic logic nxt_loop(input logic cur, input logic en, input logic lcl,
                                      input logic [5:0] c, input logic [5:0] act_c,
                                      input logic [5:0] deact_c);
        if (!en) nxt_loop = 0;
        else if (c == deact_c || c == UD) nxt_loop = 0;
        else if (c == act_c && !lcl) nxt_loop = 1;
        else nxt_loop = cur;
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " payload_loop"}, 32'(payload_loop), 32'(m_pl | force_pl));
        chk({tag, " remote_loop"}, 32'(remote_loop), 32'(m_rl | force_rl));
        chk({tag, " status"}, 32'(status), 32'(m_st));
        chk({tag, " irq R11"}, 32'(irq), 32'(|(m_st & ~irq_mask)));
    endtask

    // Serialise one message: 0, code MSB first, 0, eight ones (R1).
    task automatic send_msg(input logic [5:0] c, input logic apply, input logic [3:0] clr);
        logic [15:0] fr;
        fr = {1'b0, c, 1'b0, 8'hFF};
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); dl_valid = 1; dl_bit = fr[i];
        end
        @(negedge clk); dl_valid = 0; dl_bit = 1;
        @(negedge clk); status_clr = clr;
        @(negedge clk); status_clr = 0;
        if (apply) begin
            m_st = (m_st & ~clr) | set_bits(c);
            m_pl = nxt_loop(m_pl, auto_pl_en, force_local, c, PA, PD);
            m_rl = nxt_loop(m_rl, auto_ln_en, force_local, c, LA, LD);
        end else begin
            m_st = m_st & ~clr;
        end
    endtask

    task automatic set_en(input logic pl, input logic ln);
        @(negedge clk); auto_pl_en = pl; auto_ln_en = ln;
        if (!pl) m_pl = 0;
        if (!ln) m_rl = 0;
        @(negedge clk);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_all("R12 reset");
        chk("R12 reset msg_accept", 32'(msg_accept), 0);
        rst_n = 1;

        // R1 R2 R8: unfiltered accept, flags set with switching off
        base = acc_cnt;
        send_msg(PA, 1, 0);
        chk("R2 one accept", 32'(acc_cnt - base), 1);
        chk("R1 code", 32'(last_code), 32'(PA));
        check_all("R8 flag without enable");

        // R4: payload activate and deactivate
        set_en(1, 0);
        chk("R7 enable not retroactive", 32'(payload_loop), 0);
        send_msg(PA, 1, 0);
        check_all("R4 payload on");
        send_msg(PD, 1, 0);
        check_all("R4 payload off");
        force_local = 1;
        send_msg(PA, 1, 0);
        check_all("R4 local blocks");
        force_local = 0;

        // R5: line loop independent of payload
        set_en(1, 1);
        send_msg(LA, 1, 0);
        check_all("R5 line on");
        send_msg(PA, 1, 0);
        check_all("R5 both on");
        send_msg(LD, 1, 0);
        check_all("R5 line off, payload kept");

        // R6: force survives deactivate
        force_pl = 1;
        send_msg(PD, 1, 0);
        check_all("R6 forced payload");
        @(negedge clk); force_pl = 0; @(negedge clk);
        check_all("R6 force released");

        // R7: clearing enable drops the loop
        send_msg(PA, 1, 0);
        send_msg(LA, 1, 0);
        check_all("R7 loops up");
        set_en(0, 1);
        check_all("R7 payload dropped");
        set_en(1, 1);
        check_all("R7 re-enable keeps off");

        // R9: universal deactivate
        send_msg(PA, 1, 0);
        send_msg(UD, 1, 4'hF);
        check_all("R9 universal drop");
        chk("R9 flags", 32'(status), 32'b1010);
        set_en(0, 0);
        @(negedge clk); status_clr = 4'hF; @(negedge clk); status_clr = 0; m_st = 0;
        send_msg(UD, 1, 0);
        check_all("R9 universal with no loop");

        // R10: clear and set-wins
        @(negedge clk); status_clr = 4'b0010; @(negedge clk); status_clr = 0;
        m_st = m_st & 4'b1101;
        check_all("R10 clear one bit");
        send_msg(LA, 1, 4'b0100);
        chk("R10 set wins", 32'(status[2]), 1);

        // R11: mask
        irq_mask = 4'b1111; @(negedge clk);
        check_all("R11 all masked");
        irq_mask = 4'b1011; @(negedge clk);
        check_all("R11 one unmasked");
        irq_mask = 0;

        // R3: repeat filter
        filter_en = 1;
        set_en(0, 1);
        send_msg(BRK, 0, 0);
        base = acc_cnt;
        for (int i = 0; i < 6; i++) send_msg(LA, 0, 0);
        chk("R3 no accept at 6", 32'(acc_cnt - base), 0);
        check_all("R3 no switch at 6");
        send_msg(LA, 1, 0);
        chk("R3 accept at 7", 32'(acc_cnt - base), 1);
        check_all("R3 switched at 7");
        send_msg(LA, 0, 0);
        chk("R3 no accept at 8", 32'(acc_cnt - base), 1);
        base = acc_cnt;
        for (int i = 0; i < 3; i++) send_msg(LD, 0, 0);
        send_msg(BRK, 0, 0);
        for (int i = 0; i < 6; i++) send_msg(LD, 0, 0);
        chk("R3 restart after break", 32'(acc_cnt - base), 0);
        check_all("R3 line kept");
        filter_en = 0;

        // Random phase, unfiltered (R1 R2 R4 R5 R6 R8 R9 R10 R11)
        for (int n = 0; n < 60; n++) begin
            logic [5:0] c;
            logic [3:0] clr;
            int k;
            k = $urandom_range(0, 6);
            case (k)
                0: c = LA; 1: c = LD; 2: c = PA; 3: c = PD; 4: c = UD;
                default: c = 6'($urandom);
            endcase
            set_en(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0));
            force_pl = 1'($urandom_range(0, 4) == 0);
            force_rl = 1'($urandom_range(0, 4) == 0);
            force_local = 1'($urandom_range(0, 4) == 0);
            irq_mask = 4'($urandom);
            clr = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0000;
            base = acc_cnt;
            send_msg(c, 1, clr);
            chk("R2 random accept", 32'(acc_cnt - base), 1);
            chk("R1 random code", 32'(last_code), 32'(c));
            check_all("random R4 R5 R8");
        end

        // R12: reset mid-run clears state
        @(negedge clk); rst_n = 0; force_pl = 0; force_rl = 0; irq_mask = 0;
        @(negedge clk); rst_n = 1; m_pl = 0; m_rl = 0; m_st = 0;
        check_all("R12 mid reset");
        finish_run();
    end
endmodule